// File: doc/BRIEF.md
# Programmable 1-2-5 Sequence Clock Divider

This block derives a sample-rate enable from a fast reference clock. The division ratio is a mantissa of 1, 2 or 5 multiplied by a power of ten. One-hot ring counters build the ×2 and ×5 steps, and a chain of seven cascaded decade stages supplies the power of ten. A selector taps the chain at the programmed exponent and drives the result onto `int_clk`. `int_clk` is a one-cycle enable in the reference clock domain, so everything downstream stays synchronous.

A host writes the block through an active-low chip select, a 2-bit address and a 6-bit data word. The address picks one of four targets: the sample interval, the gate clock interval, the timer clock interval or the step clock. Every accepted write also produces a one-cycle preset pulse for the target it addressed. A write to the sample interval restarts every counter stage, so the new ratio counts cleanly from the cycle that follows. The other three targets are held here and presented to the circuits that use them.

Top module: `seq125_divider`

## Requirements
- R1: After reset all four target registers read zero, no preset pulse is active, and `int_clk` is high on every cycle because the default ratio is 1.
- R2: A write takes place on each rising clock edge where `cs_n` is low. Data is stored into the target given by `addr`: 0 is the sample interval, 1 the gate interval, 2 the timer interval and 3 the step clock. The other targets keep their values. With `cs_n` high no register changes.
- R3: In the cycle after a write edge, `preset` has exactly the bit numbered `addr` set, for one cycle. With no write, `preset` is zero.
- R4: The sample-interval word is decoded as follows. Bits [1:0] are the mantissa code: 00 gives ×1, 01 gives ×2 and 10 gives ×5. Bits [4:2] are the exponent e, from 0 to 7. The ratio R is the mantissa times 10^e reference cycles.
- R5: For R > 1, `int_clk` is a single-cycle pulse that repeats exactly every R cycles.
- R6: After a sample-interval write edge, the first `int_clk` pulse appears exactly R cycles later. Counting the cycle after the edge as cycle 1, it falls in cycle R, and no pulse comes before it.
- R7: With mantissa ×1 and exponent 0, `int_clk` is high on every cycle, including the cycle right after the write.
- R8: The reserved mantissa code 11 behaves as ×1.
- R9: Data bit 5 of the sample-interval word has no effect on the ratio.
- R10: Writes to the gate, timer or step targets do not disturb the phase or period of `int_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; low at a rising edge means a write |
| addr | input | 2 | Target select for the write |
| din | input | 6 | Write data |
| gate_ival | output | 6 | Stored gate clock interval |
| timer_ival | output | 6 | Stored timer clock interval |
| step_val | output | 6 | Stored step clock value |
| preset | output | 4 | One-cycle preset pulse per target, indexed by address |
| int_clk | output | 1 | Divided clock, one-cycle enable |

## Verification
The assertions check several rules on every cycle. The preset vector must be one-hot or zero, and it must follow the write of the previous edge. The gate register must hold when it is not addressed. A ratio of one must keep `int_clk` high. A ratio above one must never produce two pulses in a row, including the cycle after a restart. The exact period for each mantissa and exponent pair can only be shown by the bench scenarios, which count cycles from the write edge. The same holds for the reserved mantissa code, the ignored spare bit, and phase continuity across writes to other targets.

// File: rtl/seq125_pkg.sv
package seq125_pkg;

    localparam int MANT_W = 2;

    typedef enum logic [MANT_W-1:0] {
        MANT_X1  = 2'b00,
        MANT_X2  = 2'b01,
        MANT_X5  = 2'b10,
        MANT_RSV = 2'b11
    } mant_e;

    localparam logic [1:0] TGT_SAMPLE = 2'd0;
    localparam logic [1:0] TGT_GATE   = 2'd1;
    localparam logic [1:0] TGT_TIMER  = 2'd2;
    localparam logic [1:0] TGT_STEP   = 2'd3;

endpackage

// File: rtl/seq125_regif.sv
module seq125_regif #(
    parameter int DATA_W = 6,
    parameter int ADDR_W = 2,
    localparam int NUM_TGT = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] sample_q,
    output logic [DATA_W-1:0] gate_q,
    output logic [DATA_W-1:0] timer_q,
    output logic [DATA_W-1:0] step_q,
    output logic [NUM_TGT-1:0] preset_q,
    output logic              wr_sample
);
    import seq125_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0]  sample;
        logic [DATA_W-1:0]  gate;
        logic [DATA_W-1:0]  timer;
        logic [DATA_W-1:0]  step;
        logic [NUM_TGT-1:0] preset;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr;

    always_comb begin
        wr        = !cs_n;
        wr_sample = wr && (addr == ADDR_W'(TGT_SAMPLE));
        r_d        = r_q;
        r_d.preset = '0;
        if (wr) begin
            r_d.preset[addr] = 1'b1;
            case (addr)
                ADDR_W'(TGT_SAMPLE): r_d.sample = din;
                ADDR_W'(TGT_GATE):   r_d.gate   = din;
                ADDR_W'(TGT_TIMER):  r_d.timer  = din;
                default:             r_d.step   = din;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sample_q = r_q.sample;
    assign gate_q   = r_q.gate;
    assign timer_q  = r_q.timer;
    assign step_q   = r_q.step;
    assign preset_q = r_q.preset;

endmodule

// File: rtl/seq125_ring.sv
module seq125_ring #(
    parameter int LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic wrap
);
    typedef struct packed {
        logic [LEN-1:0] hot;
    } ring_t;

    ring_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) s_d.hot = LEN'(1);
        else     s_d.hot = {s_q.hot[LEN-2:0], s_q.hot[LEN-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{hot: LEN'(1)};
        else        s_q <= s_d;
    end

    assign wrap = s_q.hot[LEN-1];

endmodule

// File: rtl/seq125_decade.sv
module seq125_decade #(
    parameter int RADIX = 10,
    localparam int DIG_W = $clog2(RADIX)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cin,
    output logic cout
);
    localparam logic [DIG_W-1:0] TOP = DIG_W'(RADIX - 1);
    localparam logic [DIG_W-1:0] ONE = DIG_W'(1);

    typedef struct packed {
        logic [DIG_W-1:0] cnt;
    } dig_t;

    dig_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        cout = cin && (s_q.cnt == TOP);
        if (clr) begin
            s_d.cnt = '0;
        end else if (cin) begin
            if (s_q.cnt == TOP) s_d.cnt = '0;
            else                s_d.cnt = s_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/seq125_chain.sv
module seq125_chain #(
    parameter int NUM_STAGES = 7,
    parameter int RADIX      = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                tick_in,
    output logic [NUM_STAGES:0] taps
);
    logic [NUM_STAGES:0] carry;

    assign carry[0] = tick_in;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        seq125_decade #(.RADIX(RADIX)) u_dec (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .cin  (carry[i]),
            .cout (carry[i+1])
        );
    end

    assign taps = carry;

endmodule

// File: rtl/seq125_divider.sv
module seq125_divider #(
    parameter int DATA_W     = 6,
    parameter int ADDR_W     = 2,
    parameter int NUM_STAGES = 7,
    parameter int RADIX      = 10,
    localparam int NUM_TGT   = 1 << ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  gate_ival,
    output logic [DATA_W-1:0]  timer_ival,
    output logic [DATA_W-1:0]  step_val,
    output logic [NUM_TGT-1:0] preset,
    output logic               int_clk
);
    import seq125_pkg::*;

    localparam int EXP_W  = $clog2(NUM_STAGES + 1);
    localparam int EXP_LO = MANT_W;
    localparam int EXP_HI = MANT_W + EXP_W - 1;

    logic [DATA_W-1:0]   sample_q;
    logic                wr_sample;
    logic                wrap2, wrap5;
    logic                pre_tick;
    logic [NUM_STAGES:0] taps;
    mant_e               mant;
    logic [EXP_W-1:0]    expo;
    logic                unused_spare_bits;

    seq125_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .addr     (addr),
        .din      (din),
        .sample_q (sample_q),
        .gate_q   (gate_ival),
        .timer_q  (timer_ival),
        .step_q   (step_val),
        .preset_q (preset),
        .wr_sample(wr_sample)
    );

    seq125_ring #(.LEN(2)) u_ring2 (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wr_sample),
        .wrap (wrap2)
    );

    seq125_ring #(.LEN(5)) u_ring5 (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wr_sample),
        .wrap (wrap5)
    );

    always_comb begin
        mant = mant_e'(sample_q[MANT_W-1:0]);
        expo = sample_q[EXP_HI:EXP_LO];
        case (mant)
            MANT_X2: pre_tick = wrap2;
            MANT_X5: pre_tick = wrap5;
            default: pre_tick = 1'b1;
        endcase
    end

    seq125_chain #(.NUM_STAGES(NUM_STAGES), .RADIX(RADIX)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wr_sample),
        .tick_in(pre_tick),
        .taps   (taps)
    );

    always_comb begin
        if (int'(expo) <= NUM_STAGES) int_clk = taps[expo];
        else                          int_clk = taps[NUM_STAGES];
    end

    assign unused_spare_bits = ^sample_q[DATA_W-1:EXP_HI+1];

endmodule

// File: rtl/seq125_divider_chk.sv
module seq125_divider_chk #(
    parameter int DATA_W  = 6,
    parameter int ADDR_W  = 2,
    parameter int NUM_TGT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  din,
    input logic [DATA_W-1:0]  gate_ival,
    input logic [NUM_TGT-1:0] preset,
    input logic [DATA_W-1:0]  sample_q,
    input logic               int_clk
);
    logic q_is_one, d_is_one, wr_s, wr_g;

    always_comb begin
        q_is_one = (sample_q[1:0] != 2'b01) && (sample_q[1:0] != 2'b10) && (sample_q[4:2] == 3'd0);
        d_is_one = (din[1:0] != 2'b01) && (din[1:0] != 2'b10) && (din[4:2] == 3'd0);
        wr_s     = !cs_n && (addr == ADDR_W'(0));
        wr_g     = !cs_n && (addr == ADDR_W'(1));
    end

    // R3
    preset_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(preset));

    // R3
    preset_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> preset[$past(addr)]);

    // R3
    preset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (preset == '0));

    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_g |=> $stable(gate_ival));

    // R7
    ratio_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_is_one && !wr_s) |=> int_clk);

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && !d_is_one) |=> !int_clk);

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clk && !q_is_one && !wr_s) |=> !int_clk);

endmodule

bind seq125_divider seq125_divider_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_TGT(NUM_TGT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .addr     (addr),
    .din      (din),
    .gate_ival(gate_ival),
    .preset   (preset),
    .sample_q (sample_q),
    .int_clk  (int_clk)
);

// File: tb/seq125_divider_test.sv
module seq125_divider_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] addr = '0;
    logic [5:0] din = '0;
    logic [5:0] gate_ival, timer_ival, step_val;
    logic [3:0] preset;
    logic       int_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq125_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .addr      (addr),
        .din       (din),
        .gate_ival (gate_ival),
        .timer_ival(timer_ival),
        .step_val  (step_val),
        .preset    (preset),
        .int_clk   (int_clk)
    );

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge of cycle 1 after the write edge.
    task automatic wr(logic [1:0] a, logic [5:0] d);
        cs_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1;
        check("R3", int'(preset), 1 << a, "preset after write");
    endtask

    // Samples int_clk from cycle k0 for n cycles; pulses expected when k mod r == 0.
    task automatic measure(string req, int r, int k0, int n);
        int bad = 0, first = -1;
        for (int k = k0; k < k0 + n; k++) begin
            if (int_clk && first < 0) first = k;
            if (int_clk != ((k % r) == 0)) bad++;
            @(negedge clk);
        end
        check(req, bad, 0, $sformatf("pulse pattern mismatches, ratio %0d", r));
        if (k0 == 1) check(req, first, r, "first pulse cycle");
    endtask

    task automatic t_reset();
        check("R1", int'(gate_ival), 0, "gate after reset");
        check("R1", int'(timer_ival), 0, "timer after reset");
        check("R1", int'(step_val), 0, "step after reset");
        check("R1", int'(preset), 0, "preset after reset");
        measure("R1", 1, 1, 4);
    endtask

    task automatic t_ratio(string req, logic [1:0] m, logic [2:0] e, logic spare, int r);
        wr(2'd0, {spare, e, m});
        measure(req, r, 1, 3 * r);
    endtask

    task automatic t_targets();
        wr(2'd1, 6'h15);
        check("R2", int'(gate_ival), 6'h15, "gate value");
        wr(2'd2, 6'h2a);
        check("R2", int'(timer_ival), 6'h2a, "timer value");
        wr(2'd3, 6'h3c);
        check("R2", int'(step_val), 6'h3c, "step value");
        check("R2", int'(gate_ival), 6'h15, "gate kept");
        check("R2", int'(timer_ival), 6'h2a, "timer kept");
    endtask

    task automatic t_no_cs();
        cs_n = 1'b1; addr = 2'd1; din = 6'h07;
        @(negedge clk);
        addr = 2'd3; din = 6'h01;
        @(negedge clk);
        check("R2", int'(gate_ival), 6'h15, "gate with cs_n high");
        check("R2", int'(step_val), 6'h3c, "step with cs_n high");
        check("R3", int'(preset), 0, "preset with cs_n high");
    endtask

    task automatic t_phase();
        // ratio 5; gate write at cycle 1 and timer write at cycle 7 must not shift pulses
        wr(2'd0, 6'b000010);
        wr(2'd1, 6'h01);
        measure("R10", 5, 2, 5);
        wr(2'd2, 6'h02);
        measure("R10", 5, 8, 12);
        check("R10", int'(gate_ival), 1, "gate after phase test");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_targets();
        t_no_cs();
        t_ratio("R4", 2'b01, 3'd0, 1'b0, 2);
        t_ratio("R4", 2'b10, 3'd0, 1'b0, 5);
        t_ratio("R4", 2'b00, 3'd1, 1'b0, 10);
        t_ratio("R5", 2'b01, 3'd1, 1'b0, 20);
        t_ratio("R6", 2'b10, 3'd2, 1'b0, 500);
        t_ratio("R5", 2'b00, 3'd3, 1'b0, 1000);
        t_ratio("R8", 2'b11, 3'd1, 1'b0, 10);
        t_ratio("R9", 2'b01, 3'd0, 1'b1, 2);
        t_ratio("R7", 2'b00, 3'd0, 1'b0, 1);
        t_ratio("R8", 2'b11, 3'd0, 1'b0, 1);
        t_phase();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule